// File: doc/BRIEF.md
# Two-Wire Write-Only Control Register Slave

This block sits on a two-wire serial bus (I2C) as a write-only target and fills a bank of ten 8-bit configuration registers that steer an audio signal path: input gain, surround and effect setup, phase network selection, tone settings, four output attenuators and the input selector. A host opens a transfer with a START, sends the device address, then a subaddress byte, then one or more data bytes, and closes with a STOP. The block pulls SDA low in the ninth clock of every byte it accepts.

The subaddress carries a mode flag in its top bit. With the flag clear, every data byte of the transfer lands in the one register that was named. With the flag set, a 4-bit pointer steps by one after each byte; codes 10 to 15 have no register, so bytes aimed there are dropped, and the pointer then wraps to 0. A strap input picks one of two device addresses. Both bus lines are brought into the system clock domain through two-flop synchronizers, and the system clock must run at least eight times faster than SCL.

Top module: `ctl_i2c_regbank`

## Requirements
- R1: A falling SDA while SCL is high starts a transfer and a rising SDA while SCL is high ends it; after an end condition the block releases SDA (sda_oe = 0).
- R2: The block acknowledges an address byte of 0x80 when addr_strap is 0 and of 0x82 when addr_strap is 1 (bit 0 = 0 marks a write) by holding sda_oe = 1 through the ninth SCL high phase.
- R3: Any other address byte is not acknowledged, and every byte up to the next start condition is neither acknowledged nor written.
- R4: With subaddress bit 7 = 0, every data byte of the transfer is written to the register selected by subaddress bits 3:0; the last byte wins.
- R5: With subaddress bit 7 = 1, the first data byte goes to the selected register and each later byte to the previous target plus one, counted in 4 bits; targets 10 to 15 are dropped and the count wraps from 15 to 0.
- R6: Subaddress bits 6:4 have no effect on which register is written.
- R7: Within an addressed transfer, the subaddress byte and every data byte are acknowledged, including bytes that are dropped.
- R8: After reset the registers hold: reg0 0x3F, reg1 0x3E, reg2 0x00, reg3 0x07, reg4 0x77, reg5 to reg8 0x78 (mute), reg9 0x00; register n occupies regs_o[8n+7:8n].
- R9: A start or end condition arriving before the eighth bit of a data byte has been clocked discards that partial byte; bytes already acknowledged stay written.
- R10: A register changes only when a complete data byte aimed at it is committed.
- R11: sda_oe changes only after a falling SCL edge or a start/end condition, so it is steady while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge), 0 releases it |
| addr_strap | input | 1 | Device address select: 0 gives 0x80, 1 gives 0x82 |
| regs_o | output | 80 | Ten control registers, register n in bits 8n+7:8n |

## Verification
The bench drives a full auto-increment run across registers 8 and 9, through the six empty codes and onto register 0; a pointer that saturated, skipped the empty codes or wrote them into a neighbour would leave the wrong value in register 0 or disturb register 1. A non-incrementing subaddress with bits 6:4 set and two data bytes checks that the target neither moves nor is masked wrongly. Truncated bytes ending in a repeated start or an end condition check that a design committing on a bit count instead of the acknowledge clock would not corrupt the register. Address bytes for the wrong strap setting check that a mismatched transfer is never acknowledged and writes nothing.

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;

    // Subaddress pointer width fixed by the subaddress byte layout
    localparam int PTR_W = 4;

    typedef enum logic [2:0] {
        LNK_IDLE,
        LNK_ADDR,
        LNK_SUB,
        LNK_DATA,
        LNK_SKIP
    } link_state_e;

    // Power-on value of each control register
    function automatic logic [7:0] reg_reset_value(input int idx);
        case (idx)
            0:       return 8'h3F;   // input gain: full attenuation
            1:       return 8'h3E;   // surround off, fixed out, max effect cut
            3:       return 8'h07;   // bass flat, natural bass off
            4:       return 8'h77;   // middle / treble flat
            5, 6, 7, 8: return 8'h78; // attenuators muted
            default: return 8'h00;   // phase set, selector input 1
        endcase
    endfunction

endpackage

// File: rtl/ctl_i2c_linesync.sv
module ctl_i2c_linesync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES:0] scl_p;
        logic [STAGES:0] sda_p;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    logic  scl_now, scl_old, sda_now, sda_old;

    always_comb begin
        pipe_d       = pipe_q;
        pipe_d.scl_p = {pipe_q.scl_p[STAGES-1:0], scl_i};
        pipe_d.sda_p = {pipe_q.sda_p[STAGES-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '1;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign scl_now   = pipe_q.scl_p[STAGES-1];
    assign scl_old   = pipe_q.scl_p[STAGES];
    assign sda_now   = pipe_q.sda_p[STAGES-1];
    assign sda_old   = pipe_q.sda_p[STAGES];

    assign sda_s     = sda_now;
    assign scl_rise  = scl_now & ~scl_old;
    assign scl_fall  = ~scl_now & scl_old;
    assign start_det = scl_now & scl_old & sda_old & ~sda_now;
    assign stop_det  = scl_now & scl_old & ~sda_old & sda_now;

endmodule

// File: rtl/ctl_i2c_regfile.sv
module ctl_i2c_regfile
    import ctl_i2c_pkg::*;
#(
    parameter int NREG = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  logic [7:0]       wr_byte,
    output logic [NREG*8-1:0] regs
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [7:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (wr_en && (wr_idx == PTR_W'(i))) begin
                val_d = wr_byte;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= reg_reset_value(i);
            end else begin
                val_q <= val_d;
            end
        end

        assign regs[i*8 +: 8] = val_q;
    end

endmodule

// File: rtl/ctl_i2c_regbank.sv
module ctl_i2c_regbank
    import ctl_i2c_pkg::*;
#(
    parameter int         NREG        = 10,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] ADDR_BASE   = 7'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              addr_strap,
    output logic [NREG*8-1:0] regs_o
);

    localparam int               BIT_W    = 4;
    localparam logic [BIT_W-1:0] FULL_CNT = BIT_W'(8);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NREG - 1);

    typedef struct packed {
        link_state_e      st;
        logic [BIT_W-1:0] bits;
        logic [7:0]       shift;
        logic             in_ack;
        logic             oe;
        logic [PTR_W-1:0] ptr;
        logic             autoinc;
        logic             wr;
        logic [PTR_W-1:0] wr_idx;
        logic [7:0]       wr_byte;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [6:0]       dev_addr;
    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic [7:0]       wr_byte;

    ctl_i2c_linesync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign dev_addr = ADDR_BASE | {6'b0, addr_strap};

    always_comb begin
        fsm_d    = fsm_q;
        fsm_d.wr = 1'b0;
        if (stop_det) begin
            fsm_d.st     = LNK_IDLE;
            fsm_d.oe     = 1'b0;
            fsm_d.in_ack = 1'b0;
            fsm_d.bits   = '0;
        end else if (start_det) begin
            fsm_d.st     = LNK_ADDR;
            fsm_d.oe     = 1'b0;
            fsm_d.in_ack = 1'b0;
            fsm_d.bits   = '0;
        end else if (fsm_q.st != LNK_IDLE && fsm_q.st != LNK_SKIP) begin
            if (scl_rise && !fsm_q.in_ack && fsm_q.bits < FULL_CNT) begin
                fsm_d.shift = {fsm_q.shift[6:0], sda_s};
                fsm_d.bits  = fsm_q.bits + 1'b1;
            end else if (scl_fall && fsm_q.in_ack) begin
                // end of the acknowledge clock
                fsm_d.oe     = 1'b0;
                fsm_d.in_ack = 1'b0;
                fsm_d.bits   = '0;
            end else if (scl_fall && fsm_q.bits == FULL_CNT) begin
                // byte complete: decide and enter the acknowledge clock
                unique case (fsm_q.st)
                    LNK_ADDR: begin
                        if (fsm_q.shift == {dev_addr, 1'b0}) begin
                            fsm_d.st     = LNK_SUB;
                            fsm_d.oe     = 1'b1;
                            fsm_d.in_ack = 1'b1;
                        end else begin
                            fsm_d.st = LNK_SKIP;
                        end
                    end
                    LNK_SUB: begin
                        fsm_d.st      = LNK_DATA;
                        fsm_d.oe      = 1'b1;
                        fsm_d.in_ack  = 1'b1;
                        fsm_d.ptr     = fsm_q.shift[PTR_W-1:0];
                        fsm_d.autoinc = fsm_q.shift[7];
                    end
                    LNK_DATA: begin
                        fsm_d.oe     = 1'b1;
                        fsm_d.in_ack = 1'b1;
                        if (fsm_q.ptr <= LAST_IDX) begin
                            fsm_d.wr      = 1'b1;
                            fsm_d.wr_idx  = fsm_q.ptr;
                            fsm_d.wr_byte = fsm_q.shift;
                        end
                        if (fsm_q.autoinc) begin
                            fsm_d.ptr = fsm_q.ptr + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{st: LNK_IDLE, default: '0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign sda_oe  = fsm_q.oe;
    assign wr_en   = fsm_q.wr;
    assign wr_idx  = fsm_q.wr_idx;
    assign wr_byte = fsm_q.wr_byte;

    ctl_i2c_regfile #(
        .NREG (NREG)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_byte (wr_byte),
        .regs    (regs_o)
    );

endmodule

// File: rtl/ctl_i2c_regbank_chk.sv
module ctl_i2c_regbank_chk
    import ctl_i2c_pkg::*;
#(
    parameter int NREG = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic [NREG*8-1:0] regs_o,
    input logic              scl_fall,
    input logic              start_det,
    input logic              stop_det,
    input logic              wr_en,
    input logic [PTR_W-1:0]  wr_idx
);

    // R1: an end condition leaves SDA released
    p_stop_releases_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R11: acknowledge drive begins only after a falling SCL edge
    p_ack_after_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    // R11: without a falling edge or condition, sda_oe holds
    p_oe_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(scl_fall) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

    // R5: dropped codes never reach the register file
    p_write_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < PTR_W'(NREG)));

    // R10: registers move only after a commit pulse
    p_regs_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(regs_o));

endmodule

bind ctl_i2c_regbank ctl_i2c_regbank_chk #(.NREG(NREG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .regs_o    (regs_o),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx)
);

// File: tb/ctl_i2c_regbank_bench.sv
`timescale 1ns/1ps
module ctl_i2c_regbank_bench;

    localparam int NREG = 10;
    localparam int Q    = 400;   // quarter SCL step, 20 system clocks

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic strap = 1'b0;
    logic sda_oe;
    logic [NREG*8-1:0] regs_o;
    wire  sda_line = sda_m & ~sda_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [7:0] shadow [NREG];

    always #10 clk = ~clk;

    ctl_i2c_regbank u_ctl_i2c_regbank (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .addr_strap (strap),
        .regs_o     (regs_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q;
    endtask

    task automatic send_bits(input int n, input logic [7:0] b);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; #Q; scl_m = 1'b1; #Q; scl_m = 1'b0; #Q;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack_mid, output logic ack_late);
        send_bits(8, b);
        sda_m = 1'b1; #Q;
        scl_m = 1'b1; #(Q/2);
        ack_mid = ~sda_line;
        #(Q/2 - 20);
        ack_late = ~sda_line;
        #20; scl_m = 1'b0; #Q;
    endtask

    task automatic compare_all(input string req);
        for (int i = 0; i < NREG; i++) begin
            chk(regs_o[i*8 +: 8] == shadow[i], req, regs_o[i*8 +: 8], shadow[i]);
        end
    endtask

    task automatic t_reset();
        shadow = '{8'h3F, 8'h3E, 8'h00, 8'h07, 8'h77, 8'h78, 8'h78, 8'h78, 8'h78, 8'h00};
        compare_all("R8 reset value");
        chk(sda_oe == 1'b0, "R8 sda released in reset", sda_oe, 0);
    endtask

    task automatic t_single();
        logic a, l;
        strap = 1'b0;
        bus_start();
        send_byte(8'h80, a, l);
        chk(a, "R2 ack of 0x80 with strap 0", a, 1);
        send_byte(8'h73, a, l);
        chk(a, "R7 subaddress ack", a, 1);
        send_byte(8'hA5, a, l);
        chk(a && l, "R11 ack held across high phase", {a, l}, 2'b11);
        send_byte(8'h5A, a, l);
        chk(a, "R7 data ack", a, 1);
        bus_stop();
        #(4*Q);
        chk(sda_oe == 1'b0, "R1 released after end condition", sda_oe, 0);
        shadow[3] = 8'h5A;
        compare_all("R4 R6 single register, last byte wins");
    endtask

    task automatic t_autoinc();
        logic a, l;
        bus_start();
        send_byte(8'h80, a, l);
        send_byte(8'h88, a, l);
        send_byte(8'h11, a, l);
        send_byte(8'h22, a, l);
        for (int k = 0; k < 6; k++) begin
            send_byte(8'hEE, a, l);
            chk(a, "R7 dropped byte still acked", a, 1);
        end
        send_byte(8'h44, a, l);
        bus_stop();
        #(4*Q);
        shadow[8] = 8'h11;
        shadow[9] = 8'h22;
        shadow[0] = 8'h44;
        compare_all("R5 auto-increment with drop and wrap");
    endtask

    task automatic t_mismatch();
        logic a, l;
        strap = 1'b0;
        bus_start();
        send_byte(8'h82, a, l);
        chk(!a, "R3 wrong address not acked", a, 0);
        send_byte(8'h05, a, l);
        chk(!a, "R3 later byte not acked", a, 0);
        send_byte(8'h99, a, l);
        chk(!a, "R3 data not acked", a, 0);
        bus_stop();
        #(4*Q);
        compare_all("R10 no write after mismatch");
    endtask

    task automatic t_strap();
        logic a, l;
        strap = 1'b1;
        #(4*Q);
        bus_start();
        send_byte(8'h82, a, l);
        chk(a, "R2 ack of 0x82 with strap 1", a, 1);
        send_byte(8'h05, a, l);
        send_byte(8'h12, a, l);
        bus_stop();
        shadow[5] = 8'h12;
        bus_start();
        send_byte(8'h80, a, l);
        chk(!a, "R3 0x80 refused with strap 1", a, 0);
        send_byte(8'h05, a, l);
        send_byte(8'h34, a, l);
        bus_stop();
        #(4*Q);
        compare_all("R2 strap-selected address");
        strap = 1'b0;
        #(4*Q);
    endtask

    task automatic t_partial();
        logic a, l;
        bus_start();
        send_byte(8'h80, a, l);
        send_byte(8'h02, a, l);
        send_byte(8'h77, a, l);
        send_bits(5, 8'h00);
        bus_start();   // repeated start cuts the byte
        shadow[2] = 8'h77;
        send_byte(8'h80, a, l);
        chk(a, "R9 address after repeated start", a, 1);
        send_byte(8'h86, a, l);
        send_byte(8'h3C, a, l);
        bus_stop();
        shadow[6] = 8'h3C;
        bus_start();
        send_byte(8'h80, a, l);
        send_byte(8'h04, a, l);
        send_bits(3, 8'h00);
        bus_stop();    // end condition cuts the byte
        #(4*Q);
        compare_all("R9 partial bytes discarded");
    endtask

    initial begin
        #(3_000_000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #3 rst_n = 1'b1;
        #(4*Q);
        t_reset();
        t_single();
        t_autoinc();
        t_mismatch();
        t_strap();
        t_partial();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule